// File: doc/BRIEF.md
# DMA Channel Interrupt Status Controller

This block collects the transfer events of one logical DMA channel and turns them into a single interrupt request for the processor. The events are time-out and request collision, which are errors, and four progress markers: start of last frame, half frame, end of frame and end of block. Each event arrives as a one-cycle pulse. A six-bit mask register chooses which events are recorded. The recorded causes sit in a status register. Reading that register returns the causes and empties it.

The interrupt line is active low and level sensitive. It stays low while any cause is recorded, and only a read of the status register releases it. While the line is held low, no further event is recorded. Any error event makes the block command the transfer engine to disable the logical channel, even when that error is masked. Only an unmasked error also releases the physical channel.

Software reaches the block through a small register bus with a select strobe, a write strobe, a read strobe, a one-bit address and six data bits.

Top module: `dma_chan_irq_ctrl`

## Requirements
- R1: The reset is synchronous and active low. After reset the mask and status registers are zero, `irq_n_o` is 1, and `chan_disable_o` and `phys_release_o` are 0.
- R2: A bus write with address 0 loads the mask register from `bus_wdata_i`. A bus access with address 0 reads the mask back on `bus_rdata_o` in the same cycle. The bit layout is: bit 0 time-out, bit 1 request collision, bit 2 start of last frame, bit 3 half frame, bit 4 end of frame, bit 5 end of block.
- R3: While the status is empty, an event pulse sets its status bit (same bit position as in R2) only if its mask bit is 1. A masked event leaves the status unchanged.
- R4: `irq_n_o` is 0 in the cycle after the first status bit is set. It stays 0 until the status register is read.
- R5: A bus read with address 1 returns the status combinationally on `bus_rdata_o`. It clears every status bit at that clock edge, so `irq_n_o` is 1 afterwards.
- R6: Events that arrive while any status bit is set are dropped and are not queued.
- R7: If an event pulse and a status read fall in the same cycle, the read returns the old status. The status is then empty and the event is lost.
- R8: An unmasked error (bit 0 or bit 1) sets its status bit and lowers `irq_n_o`. It also drives `chan_disable_o` and `phys_release_o` high for exactly the one cycle after the pulse is sampled.
- R9: A masked error sets no status bit and leaves `irq_n_o` high. It still pulses `chan_disable_o` for one cycle, and `phys_release_o` stays 0.
- R10: A bus write with address 1 has no effect on the status or on `irq_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_i | input | 6 | Event pulses, bit order as in R2 |
| bus_sel_i | input | 1 | Register bus select |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 1 | 0 = mask register, 1 = status register |
| bus_wdata_i | input | 6 | Write data |
| bus_rdata_o | output | 6 | Read data, combinational from the address |
| irq_n_o | output | 1 | Active-low level interrupt |
| chan_disable_o | output | 1 | One-cycle logical channel disable command |
| phys_release_o | output | 1 | One-cycle physical channel release command |

## Verification
The assertions assume that a bus read and a bus write never arrive in the same cycle. They also assume that event pulses are already synchronous to `clk`, so any bit of `ev_i` may be high in any cycle, including during a status read. The bench changes inputs only on the falling edge, issues one bus operation at a time, and drops every event pulse after one cycle. Events during a read are applied on purpose, to check the rule for that collision.

// File: rtl/dma_irq_pkg.sv
// Shared constants and types for the channel interrupt controller.
package dma_irq_pkg;
    localparam int unsigned N_EV       = 6;
    localparam int unsigned EV_TIMEOUT = 0;
    localparam int unsigned EV_COLLIDE = 1;
    typedef logic [N_EV-1:0] ev_vec_t;
    // Bits that are error events; all others are status events.
    localparam ev_vec_t ERR_MASK = ev_vec_t'((1 << EV_TIMEOUT) | (1 << EV_COLLIDE));
    localparam logic ADDR_MASK = 1'b0;
    localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/dma_irq_regs.sv
// Mask register and read-data multiplexer.
// Assumes: bus strobes are qualified by the top module; reads are combinational.
module dma_irq_regs
    import dma_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    mask_wr_i,
    input  ev_vec_t wdata_i,
    input  logic    addr_i,
    input  ev_vec_t status_i,
    output ev_vec_t mask_o,
    output ev_vec_t rdata_o
);
    ev_vec_t mask_q;

    // Load the event mask on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_wr_i) mask_q <= wdata_i;
    end

    // Select the register seen by the bus.
    always_comb begin
        rdata_o = (addr_i == ADDR_STAT) ? status_i : mask_q;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/dma_irq_status.sv
// Status register with clear-on-read and the active-low interrupt level.
// Assumes: a clear request blocks any event of the same cycle.
module dma_irq_status
    import dma_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ev_vec_t ev_i,
    input  ev_vec_t mask_i,
    input  logic    clr_i,
    output ev_vec_t status_o,
    output logic    irq_n_o
);
    ev_vec_t status_q;
    logic    pending;

    assign pending = |status_q;

    // One bit per event source; capture only when nothing is pending.
    for (genvar g = 0; g < N_EV; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)       status_q[g] <= 1'b0;
            else if (clr_i)   status_q[g] <= 1'b0;
            else if (!pending) status_q[g] <= ev_i[g] & mask_i[g];
        end
    end

    // Drive the interrupt low while any cause is held.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_o <= 1'b1;
        else        irq_n_o <= clr_i ? 1'b1 : (pending ? 1'b0 : ~|(ev_i & mask_i));
    end

    assign status_o = status_q;
endmodule

// File: rtl/dma_irq_err.sv
// Error response: disable and release commands, registered one cycle.
// Assumes: the error pulses are synchronous to clk.
module dma_irq_err
    import dma_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ev_vec_t ev_i,
    input  ev_vec_t mask_i,
    output logic    disable_o,
    output logic    release_o
);
    ev_vec_t err_seen;
    assign err_seen = ev_i & ERR_MASK;

    // Any error disables the channel; only an unmasked one releases it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disable_o <= 1'b0;
            release_o <= 1'b0;
        end else begin
            disable_o <= |err_seen;
            release_o <= |(err_seen & mask_i);
        end
    end
endmodule

// File: rtl/dma_chan_irq_ctrl.sv
// Interrupt controller for one logical DMA channel: mask, clear-on-read status,
// active-low level interrupt and error commands.
// Assumes: one bus operation per cycle; event pulses synchronous to clk.
module dma_chan_irq_ctrl
    import dma_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_EV-1:0]     ev_i,
    input  logic                bus_sel_i,
    input  logic                bus_wr_i,
    input  logic                bus_rd_i,
    input  logic                bus_addr_i,
    input  logic [N_EV-1:0]     bus_wdata_i,
    output logic [N_EV-1:0]     bus_rdata_o,
    output logic                irq_n_o,
    output logic                chan_disable_o,
    output logic                phys_release_o
);
    ev_vec_t mask_q;
    ev_vec_t status_q;
    logic    mask_wr;
    logic    stat_rd;

    // Decode the bus strobes.
    always_comb begin
        mask_wr = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_MASK);
        stat_rd = bus_sel_i && bus_rd_i && (bus_addr_i == ADDR_STAT);
    end

    dma_irq_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_wr_i(mask_wr),
        .wdata_i  (bus_wdata_i),
        .addr_i   (bus_addr_i),
        .status_i (status_q),
        .mask_o   (mask_q),
        .rdata_o  (bus_rdata_o)
    );

    dma_irq_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev_i),
        .mask_i  (mask_q),
        .clr_i   (stat_rd),
        .status_o(status_q),
        .irq_n_o (irq_n_o)
    );

    dma_irq_err u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev_i),
        .mask_i   (mask_q),
        .disable_o(chan_disable_o),
        .release_o(phys_release_o)
    );
endmodule

// File: rtl/dma_chan_irq_ctrl_chk.sv
// Property checker for dma_chan_irq_ctrl, bound to every instance.
// Assumes: reads and writes are never issued together.
module dma_chan_irq_ctrl_chk
    import dma_irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [N_EV-1:0] ev_i,
    input logic            bus_sel_i,
    input logic            bus_rd_i,
    input logic            bus_addr_i,
    input logic            irq_n_o,
    input logic            chan_disable_o,
    input logic            phys_release_o,
    input logic [N_EV-1:0] status_q,
    input logic [N_EV-1:0] mask_q
);
    logic rd_stat;
    assign rd_stat = bus_sel_i && bus_rd_i && (bus_addr_i == ADDR_STAT);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_n_o && !chan_disable_o && !phys_release_o));

    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0 && !rd_stat) |=> ((status_q & ~$past(mask_q)) == '0));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o && !rd_stat) |=> !irq_n_o);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (irq_n_o && status_q == '0));

    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != '0 && !rd_stat) |=> $stable(status_q));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phys_release_o |-> chan_disable_o);

    p_err_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_i & ERR_MASK)) |=> chan_disable_o);
endmodule

bind dma_chan_irq_ctrl dma_chan_irq_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_i          (ev_i),
    .bus_sel_i     (bus_sel_i),
    .bus_rd_i      (bus_rd_i),
    .bus_addr_i    (bus_addr_i),
    .irq_n_o       (irq_n_o),
    .chan_disable_o(chan_disable_o),
    .phys_release_o(phys_release_o),
    .status_q      (status_q),
    .mask_q        (mask_q)
);

// File: tb/dma_chan_irq_ctrl_tb_top.sv
// Directed bench: one task per scenario; inputs change on the falling edge.
module dma_chan_irq_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] ev;
    logic       sel, wr, rd, addr;
    logic [5:0] wdata;
    logic [5:0] rdata;
    logic       irq_n, dis, rel;
    int         n_chk = 0;
    int         n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ev_i(ev),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_n_o(irq_n), .chan_disable_o(dis), .phys_release_o(rel)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ev = '0; sel = 0; wr = 0; rd = 0; addr = 0; wdata = '0;
    endtask

    task automatic bus_write(input logic a, input logic [5:0] d);
        @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); idle();
    endtask

    task automatic bus_read(input logic a, input logic [5:0] evs, output logic [5:0] d);
        @(negedge clk); sel = 1; rd = 1; addr = a; ev = evs;
        #1 d = rdata;
        @(negedge clk); idle();
    endtask

    task automatic pulse(input logic [5:0] evs);
        @(negedge clk); ev = evs;
        @(negedge clk); idle();
    endtask

    task automatic t_reset();
        logic [5:0] d;
        chk("R1 irq_n", irq_n, 1);
        chk("R1 disable", dis, 0);
        chk("R1 release", rel, 0);
        bus_read(0, 0, d); chk("R1 mask", d, 0);
        bus_read(1, 0, d); chk("R1 status", d, 0);
    endtask

    task automatic t_mask_rw();
        logic [5:0] d;
        bus_write(0, 6'h2A); bus_read(0, 0, d); chk("R2 mask 2A", d, 6'h2A);
        bus_write(0, 6'h15); bus_read(0, 0, d); chk("R2 mask 15", d, 6'h15);
    endtask

    task automatic t_gate();
        logic [5:0] d;
        bus_write(0, 6'b010100);
        pulse(6'b111100);
        chk("R4 irq low", irq_n, 0);
        bus_read(1, 0, d); chk("R3 gated status", d, 6'b010100);
        chk("R5 irq released", irq_n, 1);
        bus_read(1, 0, d); chk("R5 cleared", d, 0);
        bus_write(0, 6'b000011);
        pulse(6'b111100);
        chk("R3 masked irq", irq_n, 1);
        bus_read(1, 0, d); chk("R3 masked status", d, 0);
    endtask

    task automatic t_drop();
        logic [5:0] d;
        bus_write(0, 6'h3F);
        pulse(6'h08);
        pulse(6'h20);
        chk("R4 held low", irq_n, 0);
        bus_read(1, 0, d); chk("R6 later dropped", d, 6'h08);
        bus_read(1, 0, d); chk("R6 not queued", d, 0);
    endtask

    task automatic t_collide();
        logic [5:0] d;
        pulse(6'h04);
        bus_read(1, 6'h10, d); chk("R7 old value", d, 6'h04);
        chk("R7 irq high", irq_n, 1);
        bus_read(1, 0, d); chk("R7 event lost", d, 0);
        bus_read(1, 6'h10, d); chk("R7 empty read", d, 0);
        bus_read(1, 0, d); chk("R7 event lost when empty", d, 0);
    endtask

    task automatic t_err_on();
        logic [5:0] d;
        @(negedge clk); ev = 6'h01;
        @(negedge clk); idle();
        chk("R8 disable", dis, 1);
        chk("R8 release", rel, 1);
        chk("R8 irq", irq_n, 0);
        @(negedge clk);
        chk("R8 disable one cycle", dis, 0);
        chk("R8 release one cycle", rel, 0);
        bus_read(1, 0, d); chk("R8 status", d, 6'h01);
    endtask

    task automatic t_err_off();
        logic [5:0] d;
        bus_write(0, 6'h3C);
        @(negedge clk); ev = 6'h02;
        @(negedge clk); idle();
        chk("R9 disable", dis, 1);
        chk("R9 no release", rel, 0);
        chk("R9 irq high", irq_n, 1);
        @(negedge clk); chk("R9 disable one cycle", dis, 0);
        bus_read(1, 0, d); chk("R9 no status", d, 0);
    endtask

    task automatic t_stat_write();
        logic [5:0] d;
        bus_write(0, 6'h3F);
        bus_write(1, 6'h3F);
        chk("R10 no set irq", irq_n, 1);
        bus_read(1, 0, d); chk("R10 no set", d, 0);
        pulse(6'h10);
        bus_write(1, 6'h00);
        chk("R10 irq kept", irq_n, 0);
        bus_read(1, 0, d); chk("R10 status kept", d, 6'h10);
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_mask_rw();
        t_gate();
        t_drop();
        t_collide();
        t_err_on();
        t_err_off();
        t_stat_write();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule